// File: doc/BRIEF.md
# Saturating Backpropagation Weight Updater

This block performs on-chip training for a small two-layer network whose neurons use a hard-sigmoid activation. It keeps two weight arrays. One holds the hidden-layer weights, one for each pair of input and hidden neuron. The other holds the output-layer weights, one for each pair of hidden and output neuron. A forward engine outside the block evaluates one sample. It then hands over the inputs, the hidden and output pre-activations, the activations and a class label, and pulses `start`.

The updater captures the sample and spends one cycle forming the output errors and their linear-region gates. It then walks the hidden neurons one per cycle. In each of those cycles it updates the whole output-layer column for that hidden neuron in parallel, and the hidden neuron's complete row of input weights. Every scale factor is a power of two, so every multiply-by-constant is an arithmetic right shift. Every stored result is clamped to the signed weight range, which lets training run without wrap-around.

A load port writes individual weights while the block is idle, and a read port returns any stored weight combinationally. Activations are unsigned fractions where full scale means one. Pre-activations are signed. The linear region runs from `LIN_LO` to `LIN_HI`, both ends included, and defaults to -512..512.

Top module: `wupd_top`

## Requirements
- R1: After reset every stored weight reads 0, and `busy` and `done` are low.
- R2: While `busy` is low, `ld_en` writes `ld_val` to one weight. With `ld_sel`=0 the target is the hidden-layer weight, with row = hidden index and column = input index. With `ld_sel`=1 the target is the output-layer weight, with row = output index and column = hidden index. The read port uses the same addressing and returns the weight combinationally. An out-of-range address reads as 0 and a load to it writes nothing.
- R3: A load requested while `busy` is high changes no weight.
- R4: `start` is accepted only when `busy` is low. `busy` is then high for exactly 21 cycles. `done` is high for the single cycle that follows, with `busy` low. A `start` seen while busy is ignored.
- R5: The output error is A2 minus the label value. The label value is 255 when the label bit is 1 and 0 otherwise. An output neuron is gated when its signed pre-activation lies in [LIN_LO, LIN_HI].
- R6: For a gated output o and every hidden h, W2[o][h] becomes clamp(W2 - floor(e_o * A1_h / 2^11)).
- R7: An output-layer weight whose output neuron is not gated keeps its value.
- R8: The hidden error for neuron h is the sum, over gated outputs only, of the pre-update W2[o][h] times e_o.
- R9: If V1_h lies in the linear region and at least one output is gated, then W1[h][i] becomes clamp(W1 - floor(err_h * X_i / 2^19)) for every input i.
- R10: When the condition of R9 is false, the hidden neuron's row of weights keeps its value.
- R11: Every updated weight is clamped to [-128, 127].
- R12: The sample is captured in the cycle `start` is accepted. Later changes on the sample inputs do not affect the iteration.
- R13: A load and a `start` in the same idle cycle both take effect. The iteration then uses the freshly loaded weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one training iteration |
| x_vec | input | N_IN*A_W | Input features, unsigned, element i at bits i*A_W |
| a1_vec | input | N_HID*A_W | Hidden activations, unsigned |
| v1_vec | input | N_HID*V_W | Hidden pre-activations, signed |
| a2_vec | input | N_OUT*A_W | Output activations, unsigned |
| v2_vec | input | N_OUT*V_W | Output pre-activations, signed |
| label_vec | input | N_OUT | Target bits, one per output neuron |
| ld_en | input | 1 | Weight load strobe |
| ld_sel | input | 1 | 0 hidden layer, 1 output layer |
| ld_row | input | ROW_W | Load row index |
| ld_col | input | COL_W | Load column index |
| ld_val | input | W_W | Weight value to load |
| rd_sel | input | 1 | 0 hidden layer, 1 output layer |
| rd_row | input | ROW_W | Read row index |
| rd_col | input | COL_W | Read column index |
| rd_val | output | W_W | Addressed weight |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle end-of-iteration pulse |

## Verification
Two pairs of functions can collide. The first is a weight load and a training start in the same idle cycle. The bench drives both strobes together. It expects the loaded value to be in place before the first update step, so the result must match a model that applies the load first and then trains. The second is a load arriving in the preparation cycle right after the start. The bench drives it there, where no update step would mask it. It judges the final weights against a model that ignores that load.

// File: rtl/wupd_pkg.sv
package wupd_pkg;

  // Wide signed working type for all products and sums
  localparam int WIDE = 48;
  typedef logic signed [WIDE-1:0] wide_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_STEP} seq_st_e;

  // Pre-activation inside the hard-sigmoid slope, ends included
  function automatic logic in_linear(input wide_t v, input wide_t lo, input wide_t hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Gradient step: weight minus product scaled down by a floor shift
  function automatic wide_t descend(input wide_t w, input wide_t prod, input int unsigned sh);
    return w - (prod >>> sh);
  endfunction

endpackage

// File: rtl/wupd_seq.sv
module wupd_seq
  import wupd_pkg::*;
#(
  parameter int N_HID = 20,
  localparam int HW = $clog2(N_HID)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          cap_en,
  output logic          prep_en,
  output logic          step_en,
  output logic [HW-1:0] hsel,
  output logic          done
);

  localparam int CW = HW + 2;

  seq_st_e       st_q;
  logic [HW-1:0] h_q;
  logic          done_q;
  logic [CW-1:0] run_cnt;

  assign busy    = (st_q != ST_IDLE);
  assign cap_en  = start && (st_q == ST_IDLE);
  assign prep_en = (st_q == ST_PREP);
  assign step_en = (st_q == ST_STEP);
  assign hsel    = h_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      h_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) st_q <= ST_PREP;
        ST_PREP: begin
          st_q <= ST_STEP;
          h_q  <= '0;
        end
        ST_STEP: begin
          if (h_q == HW'(N_HID - 1)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            h_q <= h_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Cycle counter that only the length check reads
  always_ff @(posedge clk) begin
    if (!rst_n)      run_cnt <= '0;
    else if (cap_en) run_cnt <= '0;
    else if (busy)   run_cnt <= run_cnt + 1'b1;
  end

  // R4
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == CW'(N_HID + 1)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && hsel == HW'(N_HID - 1)) |=> done);

endmodule

// File: rtl/wupd_err.sv
module wupd_err
  import wupd_pkg::*;
#(
  parameter int N_OUT  = 10,
  parameter int A_W    = 8,
  parameter int V_W    = 16,
  parameter int LIN_LO = -512,
  parameter int LIN_HI = 512,
  localparam int E_W   = A_W + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prep_en,
  input  logic [N_OUT*A_W-1:0]          a2,
  input  logic [N_OUT*V_W-1:0]          v2,
  input  logic [N_OUT-1:0]              lab,
  output logic [N_OUT-1:0][E_W-1:0]     err_q,
  output logic [N_OUT-1:0]              gate_q
);

  localparam int ONE = (1 << A_W) - 1;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    wide_t e_w;
    logic  g_w;

    always_comb begin
      e_w = wide_t'(a2[o*A_W +: A_W]) - (lab[o] ? wide_t'(ONE) : wide_t'(0));
      g_w = in_linear(wide_t'($signed(v2[o*V_W +: V_W])), wide_t'(LIN_LO), wide_t'(LIN_HI));
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        err_q[o]  <= '0;
        gate_q[o] <= 1'b0;
      end else if (prep_en) begin
        err_q[o]  <= e_w[E_W-1:0];
        gate_q[o] <= g_w;
      end
    end

    // R5
    err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(err_q[o]) <= E_W'(ONE)) && ($signed(err_q[o]) >= -$signed(E_W'(ONE))));
  end

endmodule

// File: rtl/wupd_col.sv
module wupd_col
  import wupd_pkg::*;
#(
  parameter int N_IN    = 64,
  parameter int N_OUT   = 10,
  parameter int A_W     = 8,
  parameter int V_W     = 16,
  parameter int W_W     = 8,
  parameter int LIN_LO  = -512,
  parameter int LIN_HI  = 512,
  parameter int OUT_TOT = 11,
  parameter int HID_TOT = 19,
  localparam int E_W    = A_W + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_OUT-1:0][W_W-1:0] w2_col,
  input  logic [N_IN-1:0][W_W-1:0]  w1_row,
  input  logic [N_OUT-1:0][E_W-1:0] err_q,
  input  logic [N_OUT-1:0]          gate_q,
  input  logic [A_W-1:0]            a1_h,
  input  logic [V_W-1:0]            v1_h,
  input  logic [N_IN*A_W-1:0]       x,
  output logic [N_OUT-1:0][W_W-1:0] w2_new,
  output logic [N_IN-1:0][W_W-1:0]  w1_new,
  output logic                      hgate
);

  localparam int WMAX = (1 << (W_W - 1)) - 1;
  localparam int WMIN = -(1 << (W_W - 1));

  // Clamp a wide result into the signed weight range
  function automatic logic [W_W-1:0] fit_w(input wide_t v);
    if (v > wide_t'(WMAX))      return W_W'(WMAX);
    else if (v < wide_t'(WMIN)) return W_W'(WMIN);
    return v[W_W-1:0];
  endfunction

  wide_t hid_err;

  // Back-propagated error of this hidden neuron, from pre-update weights
  always_comb begin
    hid_err = '0;
    for (int o = 0; o < N_OUT; o++) begin
      if (gate_q[o])
        hid_err = hid_err + wide_t'($signed(w2_col[o])) * wide_t'($signed(err_q[o]));
    end
  end

  assign hgate = in_linear(wide_t'($signed(v1_h)), wide_t'(LIN_LO), wide_t'(LIN_HI)) && (|gate_q);

  for (genvar o = 0; o < N_OUT; o++) begin : g_w2
    always_comb begin
      w2_new[o] = fit_w(descend(wide_t'($signed(w2_col[o])),
                                wide_t'($signed(err_q[o])) * wide_t'(a1_h), OUT_TOT));
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_w1
    always_comb begin
      w1_new[i] = fit_w(descend(wide_t'($signed(w1_row[i])),
                                hid_err * wide_t'(x[i*A_W +: A_W]), HID_TOT));
    end
  end

  // R8
  nogate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q == '0) |-> (hid_err == '0));

endmodule

// File: rtl/wupd_top.sv
module wupd_top
  import wupd_pkg::*;
#(
  parameter int N_IN   = 64,
  parameter int N_HID  = 20,
  parameter int N_OUT  = 10,
  parameter int A_W    = 8,
  parameter int V_W    = 16,
  parameter int W_W    = 8,
  parameter int LIN_LO = -512,
  parameter int LIN_HI = 512,
  parameter int OUT_K_SH = 2,
  parameter int HID_K_SH = 4,
  parameter int LR_SH    = 1,
  parameter int OUT_NORM = 8,
  parameter int HID_NORM = 14,
  parameter int ROW_W = $clog2((N_HID > N_OUT) ? N_HID : N_OUT),
  parameter int COL_W = $clog2((N_IN > N_HID) ? N_IN : N_HID)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N_IN*A_W-1:0]  x_vec,
  input  logic [N_HID*A_W-1:0] a1_vec,
  input  logic [N_HID*V_W-1:0] v1_vec,
  input  logic [N_OUT*A_W-1:0] a2_vec,
  input  logic [N_OUT*V_W-1:0] v2_vec,
  input  logic [N_OUT-1:0]     label_vec,
  input  logic                 ld_en,
  input  logic                 ld_sel,
  input  logic [ROW_W-1:0]     ld_row,
  input  logic [COL_W-1:0]     ld_col,
  input  logic [W_W-1:0]       ld_val,
  input  logic                 rd_sel,
  input  logic [ROW_W-1:0]     rd_row,
  input  logic [COL_W-1:0]     rd_col,
  output logic [W_W-1:0]       rd_val,
  output logic                 busy,
  output logic                 done
);

  localparam int HW      = $clog2(N_HID);
  localparam int OW      = $clog2(N_OUT);
  localparam int IW      = $clog2(N_IN);
  localparam int E_W     = A_W + 2;
  localparam int OUT_TOT = OUT_NORM + OUT_K_SH + LR_SH;
  localparam int HID_TOT = HID_NORM + HID_K_SH + LR_SH;

  // Weight storage
  logic [W_W-1:0] w1_q [N_HID][N_IN];
  logic [W_W-1:0] w2_q [N_OUT][N_HID];

  // Captured sample
  logic [N_IN*A_W-1:0]  x_q;
  logic [N_HID*A_W-1:0] a1_q;
  logic [N_HID*V_W-1:0] v1_q;
  logic [N_OUT*A_W-1:0] a2_q;
  logic [N_OUT*V_W-1:0] v2_q;
  logic [N_OUT-1:0]     lab_q;

  logic          cap_en, prep_en, step_en, hgate;
  logic [HW-1:0] hsel;

  logic [N_OUT-1:0][E_W-1:0] err_q;
  logic [N_OUT-1:0]          gate_q;
  logic [N_OUT-1:0][W_W-1:0] w2_col, w2_new;
  logic [N_IN-1:0][W_W-1:0]  w1_row, w1_new;

  wupd_seq #(.N_HID(N_HID)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cap_en(cap_en),
    .prep_en(prep_en), .step_en(step_en), .hsel(hsel), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q   <= '0;
      a1_q  <= '0;
      v1_q  <= '0;
      a2_q  <= '0;
      v2_q  <= '0;
      lab_q <= '0;
    end else if (cap_en) begin
      x_q   <= x_vec;
      a1_q  <= a1_vec;
      v1_q  <= v1_vec;
      a2_q  <= a2_vec;
      v2_q  <= v2_vec;
      lab_q <= label_vec;
    end
  end

  wupd_err #(
    .N_OUT(N_OUT), .A_W(A_W), .V_W(V_W), .LIN_LO(LIN_LO), .LIN_HI(LIN_HI)
  ) u_err (
    .clk(clk), .rst_n(rst_n), .prep_en(prep_en), .a2(a2_q), .v2(v2_q),
    .lab(lab_q), .err_q(err_q), .gate_q(gate_q)
  );

  always_comb begin
    for (int o = 0; o < N_OUT; o++) w2_col[o] = w2_q[o][hsel];
    for (int i = 0; i < N_IN; i++)  w1_row[i] = w1_q[hsel][i];
  end

  wupd_col #(
    .N_IN(N_IN), .N_OUT(N_OUT), .A_W(A_W), .V_W(V_W), .W_W(W_W),
    .LIN_LO(LIN_LO), .LIN_HI(LIN_HI), .OUT_TOT(OUT_TOT), .HID_TOT(HID_TOT)
  ) u_col (
    .clk(clk), .rst_n(rst_n), .w2_col(w2_col), .w1_row(w1_row),
    .err_q(err_q), .gate_q(gate_q),
    .a1_h(a1_q[hsel*A_W +: A_W]), .v1_h(v1_q[hsel*V_W +: V_W]),
    .x(x_q), .w2_new(w2_new), .w1_new(w1_new), .hgate(hgate)
  );

  // Update steps own the arrays while running; loads only when idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int h = 0; h < N_HID; h++)
        for (int i = 0; i < N_IN; i++) w1_q[h][i] <= '0;
      for (int o = 0; o < N_OUT; o++)
        for (int h = 0; h < N_HID; h++) w2_q[o][h] <= '0;
    end else if (step_en) begin
      for (int o = 0; o < N_OUT; o++)
        if (gate_q[o]) w2_q[o][hsel] <= w2_new[o];
      if (hgate)
        for (int i = 0; i < N_IN; i++) w1_q[hsel][i] <= w1_new[i];
    end else if (ld_en && !busy) begin
      if (ld_sel) begin
        if (ld_row < N_OUT && ld_col < N_HID)
          w2_q[ld_row[OW-1:0]][ld_col[HW-1:0]] <= ld_val;
      end else begin
        if (ld_row < N_HID && ld_col < N_IN)
          w1_q[ld_row[HW-1:0]][ld_col[IW-1:0]] <= ld_val;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (rd_sel) begin
      if (rd_row < N_OUT && rd_col < N_HID) rd_val = w2_q[rd_row[OW-1:0]][rd_col[HW-1:0]];
    end else begin
      if (rd_row < N_HID && rd_col < N_IN) rd_val = w1_q[rd_row[HW-1:0]][rd_col[IW-1:0]];
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_hold
    // R7
    ungated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !gate_q[o]) |=> (w2_q[o][$past(hsel)] == $past(w2_q[o][hsel])));
  end

endmodule

// File: tb/sim_wupd_top.sv
module sim_wupd_top;
  localparam int CLK_P = 10;
  localparam int N_IN = 64, N_HID = 20, N_OUT = 10, A_W = 8, V_W = 16, W_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic ld_en = 1'b0, ld_sel = 1'b0, rd_sel = 1'b0;
  logic [4:0] ld_row = '0, rd_row = '0;
  logic [5:0] ld_col = '0, rd_col = '0;
  logic [7:0] ld_val = '0;
  logic [7:0] rd_val;
  logic busy, done;
  logic [N_IN*A_W-1:0]  x_vec = '0;
  logic [N_HID*A_W-1:0] a1_vec = '0;
  logic [N_HID*V_W-1:0] v1_vec = '0;
  logic [N_OUT*A_W-1:0] a2_vec = '0;
  logic [N_OUT*V_W-1:0] v2_vec = '0;
  logic [N_OUT-1:0]     label_vec = '0;

  int n_chk = 0, n_bad = 0;
  int m1[N_HID][N_IN];
  int m2[N_OUT][N_HID];
  int bx[N_IN], ba1[N_HID], bv1[N_HID], ba2[N_OUT], bv2[N_OUT];
  bit blab[N_OUT];

  always #(CLK_P/2) clk = ~clk;

  wupd_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .x_vec(x_vec), .a1_vec(a1_vec),
    .v1_vec(v1_vec), .a2_vec(a2_vec), .v2_vec(v2_vec), .label_vec(label_vec),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_row(ld_row), .ld_col(ld_col), .ld_val(ld_val),
    .rd_sel(rd_sel), .rd_row(rd_row), .rd_col(rd_col), .rd_val(rd_val),
    .busy(busy), .done(done)
  );

  function automatic longint floor_div(longint p, longint d);
    longint q = p / d;
    if ((q * d != p) && (p < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int clip8(longint v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return int'(v);
  endfunction

  function automatic bit lin(int v);
    return (v >= -512) && (v <= 512);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic rd(bit sel, int r, int c, output int v);
    rd_sel = sel; rd_row = r[4:0]; rd_col = c[5:0];
    #1;
    v = int'($signed(rd_val));
  endtask

  task automatic cmp_all(string req);
    int v;
    for (int h = 0; h < N_HID; h++)
      for (int i = 0; i < N_IN; i++) begin
        rd(1'b0, h, i, v);
        chk(v == m1[h][i], req, v, m1[h][i]);
      end
    for (int o = 0; o < N_OUT; o++)
      for (int h = 0; h < N_HID; h++) begin
        rd(1'b1, o, h, v);
        chk(v == m2[o][h], req, v, m2[o][h]);
      end
  endtask

  task automatic ld(bit sel, int r, int c, int v);
    ld_en = 1'b1; ld_sel = sel; ld_row = r[4:0]; ld_col = c[5:0]; ld_val = v[7:0];
    @(negedge clk);
    ld_en = 1'b0;
    if (sel) m2[r][c] = v; else m1[r][c] = v;
  endtask

  // mode 0: random values, else constant cval
  task automatic load_all(bit use_const, int cval);
    @(negedge clk);
    for (int h = 0; h < N_HID; h++)
      for (int i = 0; i < N_IN; i++)
        ld(1'b0, h, i, use_const ? cval : int'($urandom_range(255)) - 128);
    for (int o = 0; o < N_OUT; o++)
      for (int h = 0; h < N_HID; h++)
        ld(1'b1, o, h, use_const ? cval : int'($urandom_range(255)) - 128);
  endtask

  task automatic pack();
    for (int i = 0; i < N_IN; i++)  x_vec[i*A_W +: A_W] = bx[i][7:0];
    for (int h = 0; h < N_HID; h++) begin
      a1_vec[h*A_W +: A_W] = ba1[h][7:0];
      v1_vec[h*V_W +: V_W] = bv1[h][15:0];
    end
    for (int o = 0; o < N_OUT; o++) begin
      a2_vec[o*A_W +: A_W] = ba2[o][7:0];
      v2_vec[o*V_W +: V_W] = bv2[o][15:0];
      label_vec[o] = blab[o];
    end
  endtask

  task automatic rand_sample(int vspan);
    int hot = int'($urandom_range(N_OUT - 1));
    for (int i = 0; i < N_IN; i++) bx[i] = int'($urandom_range(255));
    for (int h = 0; h < N_HID; h++) begin
      ba1[h] = int'($urandom_range(255));
      bv1[h] = int'($urandom_range(2 * vspan)) - vspan;
    end
    for (int o = 0; o < N_OUT; o++) begin
      ba2[o] = int'($urandom_range(255));
      bv2[o] = int'($urandom_range(2 * vspan)) - vspan;
      blab[o] = (o == hot);
    end
  endtask

  // Independent restatement of the training rule
  task automatic model_train();
    longint e[N_OUT];
    bit g[N_OUT];
    bit anyg = 0;
    for (int o = 0; o < N_OUT; o++) begin
      e[o] = longint'(ba2[o]) - (blab[o] ? 255 : 0);
      g[o] = lin(bv2[o]);
      anyg = anyg | g[o];
    end
    for (int h = 0; h < N_HID; h++) begin
      longint herr = 0;
      for (int o = 0; o < N_OUT; o++)
        if (g[o]) herr += longint'(m2[o][h]) * e[o];
      for (int o = 0; o < N_OUT; o++)
        if (g[o]) m2[o][h] = clip8(m2[o][h] - floor_div(e[o] * ba1[h], 2048));
      if (lin(bv1[h]) && anyg)
        for (int i = 0; i < N_IN; i++)
          m1[h][i] = clip8(m1[h][i] - floor_div(herr * bx[i], 524288));
    end
  endtask

  // mode bits: 1 garble inputs mid-run, 2 load in prep cycle, 4 load with start, 8 start while busy
  task automatic train(int mode, string req);
    int cnt = 0;
    @(negedge clk);
    pack();
    if ((mode & 4) != 0) begin
      ld_en = 1'b1; ld_sel = 1'b1; ld_row = 5'd3; ld_col = 6'd0; ld_val = 8'd77;
      m2[3][0] = 77;
    end
    start = 1'b1;
    model_train();
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0;
    while (busy && cnt < 40) begin
      cnt++;
      if (cnt == 1 && (mode & 2) != 0) begin
        ld_en = 1'b1; ld_sel = 1'b1; ld_row = 5'd0; ld_col = 6'd0; ld_val = 8'h37;
      end
      if (cnt == 2) ld_en = 1'b0;
      if (cnt == 3 && (mode & 1) != 0) begin
        rand_sample(900);
        pack();
      end
      if (cnt == 7 && (mode & 8) != 0) start = 1'b1;
      if (cnt == 8) start = 1'b0;
      @(negedge clk);
    end
    chk(cnt == 21, "R4 busy length", cnt, 21);
    chk(done == 1'b1, "R4 done pulse", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R4 done single cycle", done, 0);
    chk(busy == 1'b0, "R4 no restart", busy, 0);
    cmp_all(req);
  endtask

  initial begin
    int v;
    void'($urandom(32'd2468));
    for (int h = 0; h < N_HID; h++) for (int i = 0; i < N_IN; i++) m1[h][i] = 0;
    for (int o = 0; o < N_OUT; o++) for (int h = 0; h < N_HID; h++) m2[o][h] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    cmp_all("R1 reset weights");

    load_all(1'b0, 0);
    cmp_all("R2 load readback");
    rd(1'b1, 12, 3, v);  chk(v == 0, "R2 out-of-range row", v, 0);
    rd(1'b1, 2, 25, v);  chk(v == 0, "R2 out-of-range col", v, 0);
    rd(1'b0, 22, 1, v);  chk(v == 0, "R2 out-of-range hidden row", v, 0);
    @(negedge clk);
    ld(1'b1, 11, 2, 5); m2[0][0] = m2[0][0];  // out-of-range load writes nothing
    cmp_all("R2 out-of-range load");

    // All pre-activations inside the slope
    rand_sample(400);
    train(0, "R5 R6 R8 R9 all gated");

    // No output gated: nothing changes
    rand_sample(400);
    for (int o = 0; o < N_OUT; o++) bv2[o] = (o % 2 == 0) ? 600 : -600;
    train(0, "R7 R10 no output gated");

    // Outputs gated, hidden outside
    rand_sample(400);
    for (int h = 0; h < N_HID; h++) bv1[h] = (h % 2 == 0) ? 513 : -513;
    train(0, "R6 R10 hidden outside");

    // Region boundaries
    rand_sample(400);
    for (int o = 0; o < N_OUT; o++) bv2[o] = (o % 4 == 0) ? -512 : (o % 4 == 1) ? 512 : (o % 4 == 2) ? -513 : 513;
    for (int h = 0; h < N_HID; h++) bv1[h] = (h % 4 == 0) ? -512 : (h % 4 == 1) ? 512 : (h % 4 == 2) ? -513 : 513;
    train(0, "R5 R7 R9 R10 boundary");

    // Saturation high
    load_all(1'b1, 127);
    rand_sample(100);
    for (int i = 0; i < N_IN; i++) bx[i] = 255;
    for (int h = 0; h < N_HID; h++) ba1[h] = 255;
    for (int o = 0; o < N_OUT; o++) begin ba2[o] = 0; blab[o] = 1'b1; end
    train(0, "R11 clamp high");

    // Saturation low
    load_all(1'b1, -128);
    rand_sample(100);
    for (int i = 0; i < N_IN; i++) bx[i] = 255;
    for (int h = 0; h < N_HID; h++) ba1[h] = 255;
    for (int o = 0; o < N_OUT; o++) begin ba2[o] = 0; blab[o] = 1'b1; end
    train(0, "R11 clamp low");

    // Capture, load while busy, start while busy
    load_all(1'b0, 0);
    rand_sample(500);
    train(1 | 2 | 8, "R3 R4 R12 busy interference");

    // Load and start together
    rand_sample(500);
    train(4, "R13 load with start");

    for (int n = 0; n < 25; n++) begin
      rand_sample(700);
      train(0, "R5 R6 R7 R8 R9 R10 R11 random");
    end

    summary();
    $finish;
  end

endmodule